// File: doc/BRIEF.md
# SD Command Issue Register Frontend

This block is the register-side front end of an SD host controller. Software programs an argument, a packed command word and, for data commands, a block length and a block count. A write to the send register then launches exactly one command. The frontend latches the programmed values and offers them to a command-line engine over a valid/ready handshake. It then waits for the engine to report how the command phase ended and, where one applies, how the busy or data phase ended.

Completion results go into two event registers, one for the command phase and one for the data phase, and both use the same done/error bit layout. The response bits returned by the engine are placed in a four-word response store, with a placement that depends on the response class. A one-cycle interrupt request marks the end of the whole command. CRC, line serialisation and DMA movement belong to the engine and are not part of this block.

Top module: `sdf_cmd_frontend`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0, `busy` and `irq_cmd_done` are 0, and `eng_req_valid` is 0.
- R2: The register map is: argument at 0x00 (32 bits, read/write); command word at 0x04, holding opcode in bits 15:8, transfer type in bits 6:5 and response type in bits 1:0, with every other bit reading 0; block length at 0x24 (16 bits, upper bits read 0); block count at 0x28 (32 bits). Any unmapped word address reads 0.
- R3: A write to 0x08 with bit 0 set, made while idle, sets `busy` on the next cycle and raises `eng_req_valid`. While valid is high, the engine outputs carry the opcode, argument, transfer type, response type, block length and block count that were in the registers at launch. They stay unchanged until the cycle in which `eng_req_ready` is seen high.
- R4: A send write made while a command is in progress is ignored: the latched request does not change and no second request is raised. Writes to the command word during that time still update the register.
- R5: Accepting a launch clears both event registers (0x1C command event, 0x20 data event) to 0.
- R6: When the engine reports the command phase, the command event becomes {status, 1}: bit 0 = done, bit 1 = write error, bit 2 = timeout, bit 3 = CRC error, where `eng_cmd_status` bits 0..2 map to bits 1..3. The value 1 means success.
- R7: Transfer type codes are 0 none, 1 read, 2 write. Response type codes are 0 none, 1 short, 2 long, 3 short with busy. Response words sit at 0x0C, 0x10, 0x14 and 0x18. A short or short-with-busy response writes `eng_resp[39:8]` to 0x18 and `eng_resp[7:0]`, zero-extended, to 0x14, and leaves 0x0C and 0x10 as they were. A long response writes `eng_resp[127:96]` to 0x0C, `[95:64]` to 0x10, `[63:32]` to 0x14 and `[31:0]` to 0x18.
- R8: A command whose response type is none leaves all four response words unchanged.
- R9: The data event is written as {status, 1} only when a data phase ends for a command whose transfer type is not none. It stays 0 for no-transfer commands and for commands whose command phase reported an error, and such commands skip the data phase.
- R10: A successful short-with-busy command without transfer stays in progress until `eng_dat_done`, and that completion does not alter the data event.
- R11: `irq_cmd_done` is high for exactly one cycle. That is the cycle after the final completion edge (command phase on error or when no further phase is due, otherwise the data/busy phase), and `busy` is 0 in the same cycle.
- R12: Reading 0x08 returns `busy` in bit 0 and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| eng_req_valid | output | 1 | Command request offered to the engine |
| eng_req_ready | input | 1 | Engine takes the request |
| eng_opcode | output | 8 | Latched opcode |
| eng_arg | output | DATA_W | Latched argument |
| eng_xfer | output | 2 | Latched transfer type |
| eng_rsp | output | 2 | Latched response type |
| eng_blk_len | output | BLKLEN_W | Latched block length |
| eng_blk_cnt | output | BLKCNT_W | Latched block count |
| eng_cmd_done | input | 1 | Command phase finished (one cycle) |
| eng_cmd_status | input | 3 | Command phase errors: bit0 write, bit1 timeout, bit2 CRC |
| eng_resp | input | RESP_WORDS*DATA_W | Response bits, valid with `eng_cmd_done` |
| eng_dat_done | input | 1 | Data or busy phase finished (one cycle) |
| eng_dat_status | input | 3 | Data phase errors, same layout as command status |
| busy | output | 1 | A command is in progress |
| irq_cmd_done | output | 1 | One-cycle completion interrupt request |

## Verification
The assertions assume an engine that keeps to the protocol. It pulses `eng_cmd_done` only after it has taken the request, pulses `eng_dat_done` only when a data or busy phase is due, and never raises both in the same cycle. The bench's engine stub works through each command in that order. Every done pulse lasts one cycle, and every done pulse is separated from the handshake by at least one cycle. Bus writes come one at a time and never overlap a done pulse in a way that could reorder a launch.

// File: rtl/sdf_pkg.sv
// Shared constants and types for the SD command frontend.
// Assumes a word-addressed register bus with 4-byte spacing.
package sdf_pkg;
    localparam int OPC_W      = 8;
    localparam int STAT_W     = 3;
    localparam int EVT_W      = STAT_W + 1;
    localparam int SHORT_LO_W = 8;

    // Command word field positions (decoded by software and the engine).
    localparam int CW_OPC_LSB  = 8;
    localparam int CW_XFER_LSB = 5;
    localparam int CW_RSP_LSB  = 0;

    localparam logic [1:0] XFER_NONE  = 2'd0;
    localparam logic [1:0] XFER_READ  = 2'd1;
    localparam logic [1:0] XFER_WRITE = 2'd2;

    localparam logic [1:0] RSP_NONE  = 2'd0;
    localparam logic [1:0] RSP_SHORT = 2'd1;
    localparam logic [1:0] RSP_LONG  = 2'd2;
    localparam logic [1:0] RSP_BUSY  = 2'd3;

    localparam int OFF_ARG  = 'h00;
    localparam int OFF_CMD  = 'h04;
    localparam int OFF_SEND = 'h08;
    localparam int OFF_RESP = 'h0C;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WCMD,
        ST_WDAT
    } seq_state_e;

    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic [1:0]       xfer;
        logic [1:0]       rsp;
    } cmd_word_t;
endpackage

// File: rtl/sdf_regs.sv
// Software-writable registers: argument, command word, block length and
// block count, plus decode of the send strobe.
// Assumes one write per cycle; reads are handled by the top level.
module sdf_regs
    import sdf_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int BLKLEN_W = 16,
    parameter int BLKCNT_W = 32,
    parameter int OFF_BLEN = 'h24,
    parameter int OFF_BCNT = 'h28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   arg_q,
    output cmd_word_t           cmd_q,
    output logic [BLKLEN_W-1:0] blen_q,
    output logic [BLKCNT_W-1:0] bcnt_q,
    output logic                send_pulse
);
    localparam logic [ADDR_W-1:0] A_ARG  = ADDR_W'(OFF_ARG);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_SEND = ADDR_W'(OFF_SEND);
    localparam logic [ADDR_W-1:0] A_BLEN = ADDR_W'(OFF_BLEN);
    localparam logic [ADDR_W-1:0] A_BCNT = ADDR_W'(OFF_BCNT);

    // Send strobe: a write of bit 0 = 1 to the send address.
    assign send_pulse = wr_en && (addr == A_SEND) && wdata[0];

    // Register update on bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q  <= '0;
            cmd_q  <= '0;
            blen_q <= '0;
            bcnt_q <= '0;
        end else if (wr_en) begin
            if (addr == A_ARG)  arg_q <= wdata;
            if (addr == A_CMD) begin
                cmd_q.opcode <= wdata[CW_OPC_LSB +: OPC_W];
                cmd_q.xfer   <= wdata[CW_XFER_LSB +: 2];
                cmd_q.rsp    <= wdata[CW_RSP_LSB +: 2];
            end
            if (addr == A_BLEN) blen_q <= wdata[BLKLEN_W-1:0];
            if (addr == A_BCNT) bcnt_q <= wdata[BLKCNT_W-1:0];
        end
    end
endmodule

// File: rtl/sdf_seq.sv
// Command sequencer: latches a request on launch, offers it to the line
// engine, then tracks the command phase and the optional busy/data phase.
// Assumes the engine pulses done signals only after taking the request.
module sdf_seq
    import sdf_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BLKLEN_W = 16,
    parameter int BLKCNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                send_pulse,
    input  cmd_word_t           cmd_in,
    input  logic [DATA_W-1:0]   arg_in,
    input  logic [BLKLEN_W-1:0] blen_in,
    input  logic [BLKCNT_W-1:0] bcnt_in,
    input  logic                req_ready,
    input  logic                cmd_done,
    input  logic [STAT_W-1:0]   cmd_status,
    input  logic                dat_done,
    output logic                req_valid,
    output cmd_word_t           req_cmd,
    output logic [DATA_W-1:0]   req_arg,
    output logic [BLKLEN_W-1:0] req_blen,
    output logic [BLKCNT_W-1:0] req_bcnt,
    output logic                launch,
    output logic                cap_cmd,
    output logic                cap_dat,
    output logic                busy,
    output logic                irq
);
    seq_state_e state_q;
    logic       cmd_final;

    assign launch    = send_pulse && (state_q == ST_IDLE);
    assign req_valid = (state_q == ST_REQ);
    assign busy      = (state_q != ST_IDLE);
    assign cap_cmd   = (state_q == ST_WCMD) && cmd_done;
    assign cap_dat   = (state_q == ST_WDAT) && dat_done && (req_cmd.xfer != XFER_NONE);

    // Command phase ends the command on error or when no later phase is due.
    assign cmd_final = (|cmd_status) ||
                       ((req_cmd.xfer == XFER_NONE) && (req_cmd.rsp != RSP_BUSY));

    // Phase tracking and request latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            req_cmd  <= '0;
            req_arg  <= '0;
            req_blen <= '0;
            req_bcnt <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (launch) begin
                    state_q  <= ST_REQ;
                    req_cmd  <= cmd_in;
                    req_arg  <= arg_in;
                    req_blen <= blen_in;
                    req_bcnt <= bcnt_in;
                end
                ST_REQ:  if (req_ready) state_q <= ST_WCMD;
                ST_WCMD: if (cmd_done)  state_q <= cmd_final ? ST_IDLE : ST_WDAT;
                ST_WDAT: if (dat_done)  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // One-cycle completion interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (cap_cmd && cmd_final) || ((state_q == ST_WDAT) && dat_done);
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_cmd) && $stable(req_arg)); // R3
    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WCMD) && send_pulse |=> !req_valid); // R4
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R11
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy); // R11
endmodule

// File: rtl/sdf_status.sv
// Event registers and response store. Events are cleared on launch and
// written as {status, done}; response words are filled by response class.
// Assumes cap_cmd and cap_dat are never high together with launch.
module sdf_status
    import sdf_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int RESP_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         launch,
    input  logic                         cap_cmd,
    input  logic [STAT_W-1:0]            cmd_status,
    input  logic [1:0]                   rsp_type,
    input  logic [RESP_WORDS*DATA_W-1:0] resp_in,
    input  logic                         cap_dat,
    input  logic [STAT_W-1:0]            dat_status,
    output logic [EVT_W-1:0]             cmd_evt,
    output logic [EVT_W-1:0]             dat_evt,
    output logic [RESP_WORDS*DATA_W-1:0] resp_flat
);
    localparam int SHORT_HI = RESP_WORDS - 1;
    localparam int SHORT_LO = RESP_WORDS - 2;

    logic is_short;
    assign is_short = (rsp_type == RSP_SHORT) || (rsp_type == RSP_BUSY);

    // Command event: cleared on launch, written on command completion.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_evt <= '0;
        else if (launch)  cmd_evt <= '0;
        else if (cap_cmd) cmd_evt <= {cmd_status, 1'b1};
    end

    // Data event: cleared on launch, written when a data phase ends.
    always_ff @(posedge clk) begin
        if (!rst_n)       dat_evt <= '0;
        else if (launch)  dat_evt <= '0;
        else if (cap_dat) dat_evt <= {dat_status, 1'b1};
    end

    for (genvar k = 0; k < RESP_WORDS; k++) begin : g_word
        logic [DATA_W-1:0] word_q;
        logic [DATA_W-1:0] word_d;

        // Next value of this response word by response class.
        always_comb begin
            word_d = word_q;
            if (cap_cmd) begin
                if (rsp_type == RSP_LONG)
                    word_d = resp_in[(RESP_WORDS-1-k)*DATA_W +: DATA_W];
                else if (is_short && (k == SHORT_HI))
                    word_d = resp_in[SHORT_LO_W +: DATA_W];
                else if (is_short && (k == SHORT_LO))
                    word_d = DATA_W'(resp_in[SHORT_LO_W-1:0]);
            end
        end

        // Response word storage.
        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign resp_flat[k*DATA_W +: DATA_W] = word_q;
    end

    AST_CLEAR_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (cmd_evt == '0) && (dat_evt == '0)); // R5
    AST_DONE_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_evt[EVT_W-1:1]) |-> cmd_evt[0]); // R6
    AST_NONE_KEEPS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        cap_cmd && (rsp_type == RSP_NONE) |=> $stable(resp_flat)); // R8
    AST_DAT_EVT_ONLY_ON_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_dat && !launch |=> $stable(dat_evt)); // R9
endmodule

// File: rtl/sdf_cmd_frontend.sv
// Top of the SD command issue frontend: register file, sequencer and
// status store, plus the combinational register read multiplexer.
// Assumes DATA_W >= 16 and RESP_WORDS >= 2.
module sdf_cmd_frontend
    import sdf_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int RESP_WORDS = 4,
    parameter int BLKLEN_W   = 16,
    parameter int BLKCNT_W   = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr_en,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic                         eng_req_valid,
    input  logic                         eng_req_ready,
    output logic [OPC_W-1:0]             eng_opcode,
    output logic [DATA_W-1:0]            eng_arg,
    output logic [1:0]                   eng_xfer,
    output logic [1:0]                   eng_rsp,
    output logic [BLKLEN_W-1:0]          eng_blk_len,
    output logic [BLKCNT_W-1:0]          eng_blk_cnt,
    input  logic                         eng_cmd_done,
    input  logic [STAT_W-1:0]            eng_cmd_status,
    input  logic [RESP_WORDS*DATA_W-1:0] eng_resp,
    input  logic                         eng_dat_done,
    input  logic [STAT_W-1:0]            eng_dat_status,
    output logic                         busy,
    output logic                         irq_cmd_done
);
    localparam int OFF_CEVT = OFF_RESP + 4 * RESP_WORDS;
    localparam int OFF_DEVT = OFF_CEVT + 4;
    localparam int OFF_BLEN = OFF_DEVT + 4;
    localparam int OFF_BCNT = OFF_BLEN + 4;

    logic [DATA_W-1:0]            arg_q;
    cmd_word_t                    cmd_q;
    logic [BLKLEN_W-1:0]          blen_q;
    logic [BLKCNT_W-1:0]          bcnt_q;
    logic                         send_pulse;
    cmd_word_t                    req_cmd;
    logic                         launch;
    logic                         cap_cmd;
    logic                         cap_dat;
    logic [EVT_W-1:0]             cmd_evt;
    logic [EVT_W-1:0]             dat_evt;
    logic [RESP_WORDS*DATA_W-1:0] resp_flat;

    sdf_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLKLEN_W(BLKLEN_W),
        .BLKCNT_W(BLKCNT_W), .OFF_BLEN(OFF_BLEN), .OFF_BCNT(OFF_BCNT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .arg_q(arg_q), .cmd_q(cmd_q), .blen_q(blen_q),
        .bcnt_q(bcnt_q), .send_pulse(send_pulse)
    );

    sdf_seq #(
        .DATA_W(DATA_W), .BLKLEN_W(BLKLEN_W), .BLKCNT_W(BLKCNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .send_pulse(send_pulse), .cmd_in(cmd_q),
        .arg_in(arg_q), .blen_in(blen_q), .bcnt_in(bcnt_q),
        .req_ready(eng_req_ready), .cmd_done(eng_cmd_done),
        .cmd_status(eng_cmd_status), .dat_done(eng_dat_done),
        .req_valid(eng_req_valid), .req_cmd(req_cmd), .req_arg(eng_arg),
        .req_blen(eng_blk_len), .req_bcnt(eng_blk_cnt), .launch(launch),
        .cap_cmd(cap_cmd), .cap_dat(cap_dat), .busy(busy), .irq(irq_cmd_done)
    );

    sdf_status #(
        .DATA_W(DATA_W), .RESP_WORDS(RESP_WORDS)
    ) u_status (
        .clk(clk), .rst_n(rst_n), .launch(launch), .cap_cmd(cap_cmd),
        .cmd_status(eng_cmd_status), .rsp_type(req_cmd.rsp), .resp_in(eng_resp),
        .cap_dat(cap_dat), .dat_status(eng_dat_status), .cmd_evt(cmd_evt),
        .dat_evt(dat_evt), .resp_flat(resp_flat)
    );

    assign eng_opcode = req_cmd.opcode;
    assign eng_xfer   = req_cmd.xfer;
    assign eng_rsp    = req_cmd.rsp;

    // Register read multiplexer; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_ARG))  bus_rdata = arg_q;
        if (bus_addr == ADDR_W'(OFF_CMD))
            bus_rdata = DATA_W'({cmd_q.opcode, 1'b0, cmd_q.xfer, 3'b000, cmd_q.rsp});
        if (bus_addr == ADDR_W'(OFF_SEND)) bus_rdata = DATA_W'(busy);
        for (int k = 0; k < RESP_WORDS; k++)
            if (bus_addr == ADDR_W'(OFF_RESP + 4 * k))
                bus_rdata = resp_flat[k*DATA_W +: DATA_W];
        if (bus_addr == ADDR_W'(OFF_CEVT)) bus_rdata = DATA_W'(cmd_evt);
        if (bus_addr == ADDR_W'(OFF_DEVT)) bus_rdata = DATA_W'(dat_evt);
        if (bus_addr == ADDR_W'(OFF_BLEN)) bus_rdata = DATA_W'(blen_q);
        if (bus_addr == ADDR_W'(OFF_BCNT)) bus_rdata = DATA_W'(bcnt_q);
    end

    AST_BUSY_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_valid |-> busy); // R3
    AST_SEND_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_SEND)) |-> (bus_rdata[0] == busy)); // R12
endmodule

// File: tb/sdf_cmd_frontend_tb.sv
module sdf_cmd_frontend_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr_en = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         eng_req_valid;
    logic         eng_req_ready = 1'b0;
    logic [7:0]   eng_opcode;
    logic [31:0]  eng_arg;
    logic [1:0]   eng_xfer;
    logic [1:0]   eng_rsp;
    logic [15:0]  eng_blk_len;
    logic [31:0]  eng_blk_cnt;
    logic         eng_cmd_done = 1'b0;
    logic [2:0]   eng_cmd_status = '0;
    logic [127:0] eng_resp = '0;
    logic         eng_dat_done = 1'b0;
    logic [2:0]   eng_dat_status = '0;
    logic         busy;
    logic         irq_cmd_done;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    sdf_cmd_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_req_valid(eng_req_valid),
        .eng_req_ready(eng_req_ready), .eng_opcode(eng_opcode), .eng_arg(eng_arg),
        .eng_xfer(eng_xfer), .eng_rsp(eng_rsp), .eng_blk_len(eng_blk_len),
        .eng_blk_cnt(eng_blk_cnt), .eng_cmd_done(eng_cmd_done),
        .eng_cmd_status(eng_cmd_status), .eng_resp(eng_resp),
        .eng_dat_done(eng_dat_done), .eng_dat_status(eng_dat_status),
        .busy(busy), .irq_cmd_done(irq_cmd_done)
    );

    // Behavioural reference model, updated on each rising edge.
    int          m_st = 0;           // 0 idle, 1 offered, 2 command phase, 3 data/busy phase
    logic [31:0] m_arg, m_cmd, m_bcnt, m_larg, m_lcmd, m_lbcnt;
    logic [15:0] m_blen, m_lblen;
    logic [3:0]  m_cevt, m_devt;
    logic [31:0] m_resp [4];
    bit          m_irq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_arg = 0; m_cmd = 0; m_bcnt = 0; m_blen = 0;
            m_larg = 0; m_lcmd = 0; m_lbcnt = 0; m_lblen = 0;
            m_cevt = 0; m_devt = 0; m_irq = 0;
            foreach (m_resp[i]) m_resp[i] = 0;
        end else begin
            bit go;
            go = bus_wr_en && bus_addr == 6'h08 && bus_wdata[0] && m_st == 0;
            m_irq = 0;
            case (m_st)
                0: if (go) begin
                    m_st = 1; m_lcmd = m_cmd; m_larg = m_arg;
                    m_lblen = m_blen; m_lbcnt = m_bcnt; m_cevt = 0; m_devt = 0;
                end
                1: if (eng_req_ready) m_st = 2;
                2: if (eng_cmd_done) begin
                    m_cevt = {eng_cmd_status, 1'b1};
                    if (m_lcmd[1:0] == 2'd2)
                        for (int i = 0; i < 4; i++) m_resp[i] = eng_resp[127-32*i -: 32];
                    else if (m_lcmd[1:0] != 2'd0) begin
                        m_resp[3] = eng_resp[39:8];
                        m_resp[2] = {24'd0, eng_resp[7:0]};
                    end
                    if (eng_cmd_status != 0 || (m_lcmd[6:5] == 0 && m_lcmd[1:0] != 3)) begin
                        m_st = 0; m_irq = 1;
                    end else m_st = 3;
                end
                3: if (eng_dat_done) begin
                    if (m_lcmd[6:5] != 0) m_devt = {eng_dat_status, 1'b1};
                    m_st = 0; m_irq = 1;
                end
                default: m_st = 0;
            endcase
            if (bus_wr_en) begin
                case (bus_addr)
                    6'h00: m_arg = bus_wdata;
                    6'h04: m_cmd = bus_wdata & 32'h0000FF63;
                    6'h24: m_blen = bus_wdata[15:0];
                    6'h28: m_bcnt = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk("R12 busy", busy, m_st != 0);
            chk("R3 valid", eng_req_valid, m_st == 1);
            chk("R11 irq", irq_cmd_done, m_irq);
            if (m_st == 1) begin
                chk("R3/R4 opcode", eng_opcode, m_lcmd[15:8]);
                chk("R3 arg", eng_arg, m_larg);
                chk("R3 xfer", eng_xfer, m_lcmd[6:5]);
                chk("R3 rsp", eng_rsp, m_lcmd[1:0]);
                chk("R3 blklen", eng_blk_len, m_lblen);
                chk("R3 blkcnt", eng_blk_cnt, m_lbcnt);
            end
        end
    end

    function automatic logic [31:0] mread(logic [5:0] a);
        case (a)
            6'h00: return m_arg;
            6'h04: return m_cmd;
            6'h08: return {31'd0, m_st != 0};
            6'h0C: return m_resp[0];
            6'h10: return m_resp[1];
            6'h14: return m_resp[2];
            6'h18: return m_resp[3];
            6'h1C: return {28'd0, m_cevt};
            6'h20: return {28'd0, m_devt};
            6'h24: return {16'd0, m_blen};
            6'h28: return m_bcnt;
            default: return 32'd0;
        endcase
    endfunction

    task automatic tick;
        @(posedge clk); #1;
    endtask

    // Read a register, compare with a bench-chosen value and with the model.
    task automatic rexp(logic [5:0] a, logic [31:0] exp, string tag);
        bus_addr = a; #1;
        chk(tag, bus_rdata, exp);
        chk(tag, bus_rdata, mread(a));
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        bus_wr_en = 1; bus_addr = a; bus_wdata = d;
        tick;
        bus_wr_en = 0;
    endtask

    // Full command through the engine stub.
    task automatic issue(logic [7:0] op, logic [1:0] xf, logic [1:0] rs, logic [31:0] a,
                         int rdy_wait, logic [2:0] cst, logic [127:0] r,
                         int dat_wait, logic [2:0] dst);
        wr(6'h00, a);
        wr(6'h04, {16'd0, op, 1'b0, xf, 3'd0, rs});
        wr(6'h08, 32'd1);
        repeat (rdy_wait) tick;
        eng_req_ready = 1; tick; eng_req_ready = 0;
        tick;
        eng_resp = r; eng_cmd_status = cst; eng_cmd_done = 1; tick; eng_cmd_done = 0;
        if (cst == 0 && (xf != 0 || rs == 3)) begin
            repeat (dat_wait) tick;
            eng_dat_status = dst; eng_dat_done = 1; tick; eng_dat_done = 0;
        end
        tick;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick;
        rst_n = 1;
        tick;
        // R1: reset values
        for (int a = 0; a < 'h2C; a += 4) rexp(6'(a), 32'd0, "R1 reset read");
        chk("R1 busy", busy, 0);
        chk("R1 irq", irq_cmd_done, 0);
        chk("R1 valid", eng_req_valid, 0);

        // R2: register map and field masking
        wr(6'h04, 32'hFFFF_FFFF);
        rexp(6'h04, 32'h0000_FF63, "R2 cmd word mask");
        wr(6'h24, 32'h1234_5678);
        rexp(6'h24, 32'h0000_5678, "R2 blklen");
        wr(6'h28, 32'hCAFE_0003);
        rexp(6'h28, 32'hCAFE_0003, "R2 blkcnt");
        wr(6'h00, 32'hA5A5_0001);
        rexp(6'h00, 32'hA5A5_0001, "R2 arg");
        rexp(6'h2C, 32'd0, "R2 unmapped");
        rexp(6'h3C, 32'd0, "R2 unmapped");

        // R7/R6/R11: short response, success
        issue(8'd17, 2'd0, 2'd1, 32'h0000_0200, 2, 3'd0,
              128'hFFFF_FFFF_FFFF_FFFF_FFFF_FF12_3456_789A, 0, 3'd0);
        rexp(6'h18, 32'h1234_5678, "R7 short main word");
        rexp(6'h14, 32'h0000_009A, "R7 short low byte");
        rexp(6'h0C, 32'd0, "R7 short leaves word0");
        rexp(6'h1C, 32'd1, "R6 success value");
        rexp(6'h20, 32'd0, "R9 no data event");

        // R7: long response
        issue(8'd2, 2'd0, 2'd2, 32'd0, 0, 3'd0,
              128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 0, 3'd0);
        rexp(6'h0C, 32'h0011_2233, "R7 long w0");
        rexp(6'h10, 32'h4455_6677, "R7 long w1");
        rexp(6'h14, 32'h8899_AABB, "R7 long w2");
        rexp(6'h18, 32'hCCDD_EEFF, "R7 long w3");

        // R8: no response keeps the store
        issue(8'd0, 2'd0, 2'd0, 32'd0, 1, 3'd0, 128'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF_DEAD_BEEF, 0, 3'd0);
        rexp(6'h0C, 32'h0011_2233, "R8 resp kept");
        rexp(6'h18, 32'hCCDD_EEFF, "R8 resp kept");

        // R6/R9: timeout on a read command skips the data phase
        issue(8'd17, 2'd1, 2'd1, 32'd0, 0, 3'b010, 128'd0, 0, 3'd0);
        rexp(6'h1C, 32'd5, "R6 timeout event");
        rexp(6'h20, 32'd0, "R9 error skips data");

        // R9: read with a CRC error in the data phase
        issue(8'd18, 2'd1, 2'd1, 32'd8, 1, 3'd0, 128'd0, 3, 3'b100);
        rexp(6'h1C, 32'd1, "R6 command ok");
        rexp(6'h20, 32'd9, "R9 data crc event");

        // R9: write with clean data phase; R6 write-error on command
        issue(8'd24, 2'd2, 2'd1, 32'd0, 0, 3'd0, 128'd0, 1, 3'd0);
        rexp(6'h20, 32'd1, "R9 write data ok");
        issue(8'd24, 2'd2, 2'd1, 32'd0, 0, 3'b001, 128'd0, 0, 3'd0);
        rexp(6'h1C, 32'd3, "R6 write error event");

        // R5: launch clears events (previous cevt = 3)
        wr(6'h04, {16'd0, 8'd13, 8'h01});
        wr(6'h08, 32'd1);
        rexp(6'h1C, 32'd0, "R5 cmd event cleared");
        rexp(6'h20, 32'd0, "R5 data event cleared");
        rexp(6'h08, 32'd1, "R12 send reads busy");
        // R4: second send while offered is ignored
        tick;
        wr(6'h04, {16'd0, 8'h22, 8'h22});
        wr(6'h08, 32'd1);
        rexp(6'h04, 32'h0000_2222, "R4 cmd word still writable");
        chk("R4 opcode held", eng_opcode, 8'd13);
        eng_req_ready = 1; tick; eng_req_ready = 0;
        wr(6'h08, 32'd1);
        eng_resp = 128'h55; eng_cmd_status = 0; eng_cmd_done = 1; tick; eng_cmd_done = 0;
        tick;
        chk("R4 no second request", eng_req_valid, 0);
        rexp(6'h08, 32'd0, "R12 idle readback");

        // R10: busy response without transfer waits for the busy end
        wr(6'h04, {16'd0, 8'd7, 8'h03});
        wr(6'h08, 32'd1);
        eng_req_ready = 1; tick; eng_req_ready = 0;
        eng_resp = 128'h0; eng_cmd_status = 0; eng_cmd_done = 1; tick; eng_cmd_done = 0;
        repeat (3) tick;
        chk("R10 still busy", busy, 1);
        eng_dat_status = 3'b111; eng_dat_done = 1; tick; eng_dat_done = 0;
        rexp(6'h20, 32'd0, "R10 data event untouched");
        rexp(6'h1C, 32'd1, "R10 command event");
        tick;

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule